// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block owns the operating state of a serial engine. The engine has three modes: held in reset, running and paused. Software asks for a mode by writing a two-bit code into a control register. The controller accepts the request only while its settled flag is high. It then spends a fixed settling interval with that flag low, and afterwards shows the new mode and raises the flag again. Three registered mode outputs drive the downstream bus engine and its FIFOs. A one-cycle abort pulse tells that logic to stop its transfer and empty both FIFOs when the engine is pulled from running straight back to reset.

Leaving the paused mode for reset is guarded. A single reset request only arms a pending marker, and a second reset request is needed to perform the move. A separate reset register forces the engine back to reset from any condition, including the middle of a settling interval. A small error bank holds sticky flags for five engine error events, with a matching enable register. Software clears a flag by writing a 1 to it, and an interrupt output is raised while any enabled flag is set.

Top module: `serial_runstate_ctrl`

## Requirements
- R1: After synchronous reset the shown mode is reset, the settled flag is 1, the pending marker is 0, `core_rst_o` is 1, `run_o`, `pause_o`, `engine_abort_o` and `err_irq_o` are 0, and both error registers read 0.
- R2: Register addresses are: 0 = mode control/status, 1 = forced reset, 2 = error flags, 3 = error enables. The status read gives the mode code in bits 1:0 (10 = reset, 01 = run, 11 = pause), the settled flag in bit 2 and the pending marker in bit 3. `rd_data` is registered and shows the selected register one cycle after the edge.
- R3: After an accepted request the settled flag is low for exactly SETTLE (default 4) cycles. It then returns high, and the shown mode and the mode outputs take the new value on that same edge.
- R4: A write to the mode register while the settled flag is low is ignored.
- R5: A write of code 00 to the mode register is ignored. The mode is unchanged and the settled flag stays high.
- R6: While paused, a first write of 10 leaves the mode at pause and sets the pending marker. A second write of 10 then starts the move to reset.
- R7: While the marker is armed, a mode write with any code other than 10 clears the marker and is otherwise handled as a normal request.
- R8: `engine_abort_o` pulses for one cycle, on the edge where the mode changes from run to reset, and at no other time.
- R9: Writing bit 0 = 1 to the forced-reset register starts a move to reset at any time, even while settling, with the same settling interval. Writing bit 0 = 0 has no effect.
- R10: Error event input bit k sets flag bit k+2 (bits 6:2) on the next edge, and the flag holds. Writing 1 to a flag bit clears it, and an event in the same cycle wins. All other bits read 0.
- R11: Error enable bits 6:2 are read/write, and other bits read 0. `err_irq_o` is high one cycle after any flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write register select |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read register select |
| rd_data | output | DATA_W | Registered read data |
| err_evt_i | input | NERR | Error event strobes from the engine |
| run_o | output | 1 | Engine enabled (run mode) |
| pause_o | output | 1 | Engine paused |
| core_rst_o | output | 1 | Engine held in reset |
| engine_abort_o | output | 1 | One-cycle abort and FIFO flush on run-to-reset |
| err_irq_o | output | 1 | Enabled error flag present |

## Verification
The hardest state to reach from the ports is the armed pending marker in pause mode. A single reset write there changes nothing visible except bit 3 of the status read. The stimulus first settles into pause and then writes the reset code once. It then either clears the marker with a different code or completes the move with a second reset write, and it watches that no abort pulse occurs. A forced reset issued in the middle of a settling interval is reached by timing the two writes two cycles apart.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam logic [1:0] MODE_RESET = 2'b10;
  localparam logic [1:0] MODE_RUN   = 2'b01;
  localparam logic [1:0] MODE_PAUSE = 2'b11;
  localparam logic [1:0] MODE_NONE  = 2'b00;

  localparam int REG_MODE  = 0;
  localparam int REG_FRST  = 1;
  localparam int REG_EFLAG = 2;
  localparam int REG_EEN   = 3;

  localparam int STAT_VALID_BIT = 2;
  localparam int STAT_PEND_BIT  = 3;
endpackage

// File: rtl/srs_seq.sv
module srs_seq #(
  parameter int SETTLE = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [1:0] mode_code,
  input  logic       force_rst,
  output logic [1:0] cur_mode,
  output logic       settled,
  output logic       pending,
  output logic       run_q,
  output logic       pause_q,
  output logic       inrst_q,
  output logic       abort_q
);
  import srs_pkg::*;

  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [1:0]    tgt_q;
  logic [1:0]    cur_q;
  logic          pend_q;
  logic          legal;
  logic          arm_only;

  assign legal    = (mode_code != MODE_NONE);
  assign arm_only = (mode_code == MODE_RESET) && (cur_q == MODE_PAUSE) && !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= MODE_RESET;
      tgt_q   <= MODE_RESET;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      pause_q <= 1'b0;
      inrst_q <= 1'b1;
      abort_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (force_rst) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
        tgt_q  <= MODE_RESET;
        pend_q <= 1'b0;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q  <= 1'b0;
          cur_q   <= tgt_q;
          run_q   <= (tgt_q == MODE_RUN);
          pause_q <= (tgt_q == MODE_PAUSE);
          inrst_q <= (tgt_q == MODE_RESET);
          abort_q <= (cur_q == MODE_RUN) && (tgt_q == MODE_RESET);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (mode_wr) begin
        if (arm_only) begin
          pend_q <= 1'b1;
        end else begin
          pend_q <= 1'b0;
          if (legal) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
            tgt_q  <= mode_code;
          end
        end
      end
    end
  end

  assign cur_mode = cur_q;
  assign settled  = !busy_q;
  assign pending  = pend_q;
endmodule

// File: rtl/srs_errbank.sv
module srs_errbank #(
  parameter int NERR   = 5,
  parameter int ERR_LO = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NERR-1:0]   evt,
  input  logic              flag_wr,
  input  logic              en_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NERR-1:0]   flags,
  output logic [NERR-1:0]   enables,
  output logic              irq
);
  logic [NERR-1:0] wfield;
  assign wfield = wdata[ERR_LO +: NERR];

  for (genvar k = 0; k < NERR; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                       flags[k] <= 1'b0;
      else if (evt[k])               flags[k] <= 1'b1;
      else if (flag_wr && wfield[k]) flags[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enables <= '0;
      irq     <= 1'b0;
    end else begin
      if (en_wr) enables <= wfield;
      irq <= |(flags & enables);
    end
  end
endmodule

// File: rtl/serial_runstate_ctrl.sv
module serial_runstate_ctrl #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int SETTLE = 4,
  parameter int NERR   = 5,
  parameter int ERR_LO = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NERR-1:0]   err_evt_i,
  output logic              run_o,
  output logic              pause_o,
  output logic              core_rst_o,
  output logic              engine_abort_o,
  output logic              err_irq_o
);
  import srs_pkg::*;

  logic [1:0]      cur_mode;
  logic            st_valid;
  logic            st_pend;
  logic [NERR-1:0] err_flags;
  logic [NERR-1:0] err_en;
  logic            sel_mode, sel_frst, sel_flag, sel_en;

  assign sel_mode = wr_en && (wr_addr == ADDR_W'(REG_MODE));
  assign sel_frst = wr_en && (wr_addr == ADDR_W'(REG_FRST)) && wr_data[0];
  assign sel_flag = wr_en && (wr_addr == ADDR_W'(REG_EFLAG));
  assign sel_en   = wr_en && (wr_addr == ADDR_W'(REG_EEN));

  srs_seq #(.SETTLE(SETTLE)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .mode_wr  (sel_mode),
    .mode_code(wr_data[1:0]),
    .force_rst(sel_frst),
    .cur_mode (cur_mode),
    .settled  (st_valid),
    .pending  (st_pend),
    .run_q    (run_o),
    .pause_q  (pause_o),
    .inrst_q  (core_rst_o),
    .abort_q  (engine_abort_o)
  );

  srs_errbank #(.NERR(NERR), .ERR_LO(ERR_LO), .DATA_W(DATA_W)) u_err (
    .clk    (clk),
    .rst    (rst),
    .evt    (err_evt_i),
    .flag_wr(sel_flag),
    .en_wr  (sel_en),
    .wdata  (wr_data),
    .flags  (err_flags),
    .enables(err_en),
    .irq    (err_irq_o)
  );

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (int'(rd_addr))
      REG_MODE: begin
        rd_next[1:0]            = cur_mode;
        rd_next[STAT_VALID_BIT] = st_valid;
        rd_next[STAT_PEND_BIT]  = st_pend;
      end
      REG_EFLAG: rd_next[ERR_LO +: NERR] = err_flags;
      REG_EEN:   rd_next[ERR_LO +: NERR] = err_en;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int NERR   = 5,
  parameter int ERR_LO = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NERR-1:0]   err_evt_i,
  input logic              run_o,
  input logic              pause_o,
  input logic              core_rst_o,
  input logic              engine_abort_o,
  input logic              st_valid,
  input logic [NERR-1:0]   err_flags
);
  import srs_pkg::*;

  AST_ONE_MODE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $countones({run_o, pause_o, core_rst_o}) == 1); // R1

  AST_ABORT_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    engine_abort_o |-> (core_rst_o && $past(run_o))); // R8

  AST_MODES_MOVE_ON_SETTLE: assert property (@(posedge clk) disable iff (rst)
    !$stable({run_o, pause_o, core_rst_o}) |-> $rose(st_valid)); // R3

  AST_SETTLE_NOT_SHORT: assert property (@(posedge clk) disable iff (rst)
    $fell(st_valid) |=> !st_valid); // R3

  AST_FORCE_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(REG_FRST) && wr_data[0]) |=> !st_valid); // R9

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(REG_EFLAG) && wr_data[ERR_LO] && !err_evt_i[0])
      |=> !err_flags[0]); // R10
endmodule

bind serial_runstate_ctrl srs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NERR(NERR), .ERR_LO(ERR_LO)
) u_srs_checker (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .err_evt_i     (err_evt_i),
  .run_o         (run_o),
  .pause_o       (pause_o),
  .core_rst_o    (core_rst_o),
  .engine_abort_o(engine_abort_o),
  .st_valid      (st_valid),
  .err_flags     (err_flags)
);

// File: tb/serial_runstate_ctrl_bench.sv
module serial_runstate_ctrl_bench;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam int NERR   = 5;

  localparam logic [1:0] C_RST = 2'b10;
  localparam logic [1:0] C_RUN = 2'b01;
  localparam logic [1:0] C_PAU = 2'b11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic [NERR-1:0]   err_evt_i = '0;
  logic run_o, pause_o, core_rst_o, engine_abort_o, err_irq_o;

  int checks = 0;
  int fails  = 0;
  int aborts = 0;

  always #5 clk = ~clk;

  serial_runstate_ctrl u_serial_runstate_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .err_evt_i(err_evt_i),
    .run_o(run_o), .pause_o(pause_o), .core_rst_o(core_rst_o),
    .engine_abort_o(engine_abort_o), .err_irq_o(err_irq_o)
  );

  always @(negedge clk) if (engine_abort_o) aborts++;

  function automatic logic [31:0] stat(logic [1:0] code, logic v, logic p);
    return {28'd0, p, v, code};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (7) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 status", rd_data, stat(C_RST, 1'b1, 1'b0));
    chk("R1 modes", {29'd0, run_o, pause_o, core_rst_o}, 32'h1);
    chk("R1 abort/irq", {30'd0, engine_abort_o, err_irq_o}, 32'h0);
    rd_addr = 2'd2; @(negedge clk);
    chk("R1 flags", rd_data, 32'h0);
    rd_addr = 2'd3; @(negedge clk);
    chk("R1 enables", rd_data, 32'h0);
    rd_addr = 2'd0; @(negedge clk);
  endtask

  task automatic t_to_run();
    wr(0, {30'd0, C_RUN});
    @(negedge clk);
    chk("R3 valid drops", {31'd0, rd_data[2]}, 32'h0);
    chk("R3 no early run", {31'd0, run_o}, 32'h0);
    repeat (2) @(negedge clk);
    chk("R3 run not before settle", {31'd0, run_o}, 32'h0);
    @(negedge clk);
    chk("R3 run on settle", {31'd0, run_o}, 32'h1);
    chk("R3 valid low 4th cycle", {31'd0, rd_data[2]}, 32'h0);
    @(negedge clk);
    chk("R2 status run", rd_data, stat(C_RUN, 1'b1, 1'b0));
  endtask

  task automatic t_run_to_reset();
    int a0 = aborts;
    wr(0, {30'd0, C_RST});
    repeat (3) @(negedge clk);
    chk("R8 no early abort", {31'd0, engine_abort_o}, 32'h0);
    @(negedge clk);
    chk("R8 abort pulse", {30'd0, engine_abort_o, core_rst_o}, 32'h3);
    @(negedge clk);
    chk("R8 abort one cycle", {31'd0, engine_abort_o}, 32'h0);
    chk("R8 abort count", aborts - a0, 1);
  endtask

  task automatic t_busy_ignore();
    wr(0, {30'd0, C_PAU});
    wr(0, {30'd0, C_RUN});
    settle();
    chk("R4 write while settling ignored", {29'd0, run_o, pause_o, core_rst_o}, 32'h2);
    chk("R4 status", rd_data, stat(C_PAU, 1'b1, 1'b0));
  endtask

  task automatic t_null_code();
    wr(0, 32'h0);
    @(negedge clk);
    chk("R5 valid stays", rd_data, stat(C_PAU, 1'b1, 1'b0));
    settle();
    chk("R5 mode kept", {29'd0, run_o, pause_o, core_rst_o}, 32'h2);
  endtask

  task automatic t_pause_reset();
    int a0 = aborts;
    wr(0, {30'd0, C_RST});
    settle();
    chk("R6 single write arms only", rd_data, stat(C_PAU, 1'b1, 1'b1));
    chk("R6 still paused", {31'd0, pause_o}, 32'h1);
    wr(0, {30'd0, C_PAU});
    @(negedge clk);
    chk("R7 marker cleared", rd_data, stat(C_PAU, 1'b0, 1'b0));
    settle();
    chk("R7 settled pause", rd_data, stat(C_PAU, 1'b1, 1'b0));
    wr(0, {30'd0, C_RST});
    wr(0, {30'd0, C_RST});
    settle();
    chk("R6 two writes reach reset", rd_data, stat(C_RST, 1'b1, 1'b0));
    chk("R6 reset output", {29'd0, run_o, pause_o, core_rst_o}, 32'h1);
    chk("R8 no abort from pause", aborts - a0, 0);
  endtask

  task automatic t_force();
    int a0;
    wr(0, {30'd0, C_RUN});
    settle();
    wr(1, 32'h0);
    settle();
    chk("R9 bit0 clear no effect", {31'd0, run_o}, 32'h1);
    a0 = aborts;
    wr(1, 32'h1);
    @(negedge clk);
    chk("R9 valid drops", {31'd0, rd_data[2]}, 32'h0);
    settle();
    chk("R9 forced reset", rd_data, stat(C_RST, 1'b1, 1'b0));
    chk("R9 abort from run", aborts - a0, 1);
    wr(0, {30'd0, C_RUN});
    wr(1, 32'h1);
    settle();
    chk("R9 force during settle", {29'd0, run_o, pause_o, core_rst_o}, 32'h1);
  endtask

  task automatic t_errors();
    @(negedge clk); err_evt_i = 5'b00101;
    @(negedge clk); err_evt_i = '0;
    rd_addr = 2'd2;
    repeat (2) @(negedge clk);
    chk("R10 flags set", rd_data, 32'h14);
    chk("R11 irq off when disabled", {31'd0, err_irq_o}, 32'h0);
    wr(3, 32'hFFFF_FFFF);
    rd_addr = 2'd3;
    repeat (2) @(negedge clk);
    chk("R11 enables bits 6:2", rd_data, 32'h7C);
    chk("R11 irq on", {31'd0, err_irq_o}, 32'h1);
    rd_addr = 2'd2;
    wr(2, 32'h04);
    @(negedge clk);
    chk("R10 w1c", rd_data, 32'h10);
    wr(2, 32'h10);
    repeat (2) @(negedge clk);
    chk("R10 all clear", rd_data, 32'h0);
    chk("R11 irq off", {31'd0, err_irq_o}, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h08; err_evt_i = 5'b00010;
    @(negedge clk);
    wr_en = 1'b0; err_evt_i = '0;
    @(negedge clk);
    chk("R10 set wins", rd_data, 32'h08);
    rd_addr = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_to_run();
    t_run_to_reset();
    t_busy_ignore();
    t_null_code();
    t_pause_reset();
    t_force();
    t_errors();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule